// File: doc/BRIEF.md
# Acquisition Event Interrupt and DMA Request Gate

This block sits between the event pulses of a data-acquisition front end and the host bus. It takes single-cycle pulses for DMA terminal count (on either of two DMA channels), end of an analog-output sequence, end of an acquisition sequence, and per-channel conversion-ready and timer-update events. From these it produces one host interrupt line and two DMA request lines.

A control register holds one enable bit per interrupt source and one per DMA channel. Each interrupt source has a pending latch. The latch is set by an enabled event and stays set until one of that source's own clear strobes arrives. The clear strobes are single-cycle pulses, already decoded from host writes to dedicated addresses. The pending latches are visible as a status vector.

Each DMA request line rises on an enabled conversion or timer event for its channel. It stays high until the host controller acknowledges it.

Top module: `daq_irq_dma_gate`

## Requirements
- R1: A write with `ctl_we` high stores `ctl_wdata` bits 12 (terminal-count interrupt enable), 11 (output-sequence interrupt enable), 10 (acquisition interrupt enable), 9 (general I/O interrupt enable, stored only), 8 (DMA channel 0 enable) and 7 (DMA channel 1 enable). `ctl_q` shows these bits from the next cycle, and every other bit of `ctl_q` reads 0.
- R2: With bit 12 set, a pulse on `ev_tc_a` or `ev_tc_b` sets `pend_status[0]` in the following cycle. With bit 12 clear, such pulses never set it.
- R3: `pend_status[0]` is cleared only by `clr_tc`. `clr_timer`, `clr_dac` and `clr_daq` leave it unchanged.
- R4: With bit 11 set, a pulse on `ev_dac_done` or `ev_dac_err` sets `pend_status[1]`. Either `clr_timer` or `clr_dac` clears it, and `clr_tc` and `clr_daq` leave it unchanged.
- R5: With bit 10 set, a pulse on `ev_daq_done` or `ev_daq_err` sets `pend_status[2]`. Only `clr_daq` clears it.
- R6: When an enabled event and a clear strobe for the same source arrive in the same cycle, the pending bit is set afterwards.
- R7: `irq` is high exactly when some pending bit has its enable bit set. Clearing an enable bit drops `irq` but keeps the pending bit, and setting the enable again raises `irq`.
- R8: With its enable bit set, a pulse on `ev_conv[c]` or `ev_tmr[c]` raises `dma_req[c]` in the next cycle, where c=0 is controlled by bit 8 and c=1 by bit 7. With the enable clear, `dma_req[c]` stays low.
- R9: `dma_req[c]` stays high until a cycle with `dma_ack[c]` high, and then reads low for at least one cycle. An event that arrives in the acknowledge cycle raises the request again one cycle after it dropped.
- R10: A synchronous reset clears the control register, all pending bits, `irq` and both DMA requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write data |
| ctl_q | output | 16 | Control register readback |
| ev_tc_a | input | 1 | Terminal-count pulse, DMA channel A |
| ev_tc_b | input | 1 | Terminal-count pulse, DMA channel B |
| ev_dac_done | input | 1 | Output sequence ended normally |
| ev_dac_err | input | 1 | Output sequence aborted on error |
| ev_daq_done | input | 1 | Acquisition sequence ended normally |
| ev_daq_err | input | 1 | Acquisition sequence aborted on error |
| ev_conv | input | 2 | Conversion-ready pulse per DMA channel |
| ev_tmr | input | 2 | Timer-update pulse per DMA channel |
| clr_tc | input | 1 | Terminal-count clear strobe |
| clr_timer | input | 1 | Timer-request clear strobe |
| clr_dac | input | 1 | Output-sequence clear strobe |
| clr_daq | input | 1 | Acquisition clear strobe |
| dma_ack | input | 2 | DMA acknowledge per channel |
| dma_req | output | 2 | DMA request per channel |
| irq | output | 1 | Host interrupt |
| pend_status | output | 3 | Pending latches: bit0 terminal count, bit1 output sequence, bit2 acquisition |

## Verification
The interrupt path is swept over all eight enable combinations, every source and both event kinds of each source. This shows that the enables, the event-to-source routing and the set/mask behaviour are all correct. Each pending bit is first hit with every clear strobe that does not belong to it and then with its own. This separates a correctly wired clear from one that is shared or missing, and for the output-sequence source it tries both of its strobes. The DMA path is tried per channel with each event type and with the enable on and off, which catches swapped or merged channels. A same-cycle event plus clear, and an event plus acknowledge, exercise the priority rules and the minimum low gap.

// File: rtl/daq_gate_pkg.sv
package daq_gate_pkg;
  localparam int CTL_W     = 16;
  localparam int BIT_TC    = 12;
  localparam int BIT_DAC   = 11;
  localparam int BIT_DAQ   = 10;
  localparam int BIT_IO    = 9;
  localparam int BIT_DMA0  = 8;
  localparam int BIT_DMA1  = 7;
  localparam int N_SRC     = 3;
  localparam int N_CH      = 2;
  localparam int N_EV      = 2;
  localparam int N_CLR     = 2;

  // Bits of the control word that are kept; all others read back as zero.
  function automatic logic [CTL_W-1:0] ctl_keep_mask();
    logic [CTL_W-1:0] m;
    m = '0;
    m[BIT_TC]   = 1'b1;
    m[BIT_DAC]  = 1'b1;
    m[BIT_DAQ]  = 1'b1;
    m[BIT_IO]   = 1'b1;
    m[BIT_DMA0] = 1'b1;
    m[BIT_DMA1] = 1'b1;
    return m;
  endfunction

  // Set-dominant latch update.
  function automatic logic latch_next(logic q, logic set, logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/daq_src_latch.sv
module daq_src_latch
  import daq_gate_pkg::*;
#(
  parameter int EV_W  = N_EV,
  parameter int CLR_W = N_CLR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [EV_W-1:0]  ev,
  input  logic [CLR_W-1:0] clr,
  output logic             set_o,
  output logic             clr_o,
  output logic             pend
);
  assign set_o = en & (|ev);
  assign clr_o = |clr;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= latch_next(pend, set_o, clr_o);
  end
endmodule

// File: rtl/daq_dma_chan.sv
module daq_dma_chan (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ev_conv,
  input  logic ev_tmr,
  input  logic ack,
  output logic req
);
  logic req_q;
  logic owed_q;
  logic ev_any;

  assign ev_any = ev_conv | ev_tmr;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      req_q  <= 1'b0;
      owed_q <= 1'b0;
    end else if (req_q && ack) begin
      req_q  <= 1'b0;
      owed_q <= ev_any;
    end else if (ev_any || owed_q) begin
      req_q  <= 1'b1;
      owed_q <= 1'b0;
    end
  end

  assign req = req_q & en;
endmodule

// File: rtl/daq_irq_dma_gate.sv
module daq_irq_dma_gate
  import daq_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             ev_tc_a,
  input  logic             ev_tc_b,
  input  logic             ev_dac_done,
  input  logic             ev_dac_err,
  input  logic             ev_daq_done,
  input  logic             ev_daq_err,
  input  logic [N_CH-1:0]  ev_conv,
  input  logic [N_CH-1:0]  ev_tmr,
  input  logic             clr_tc,
  input  logic             clr_timer,
  input  logic             clr_dac,
  input  logic             clr_daq,
  input  logic [N_CH-1:0]  dma_ack,
  output logic [N_CH-1:0]  dma_req,
  output logic             irq,
  output logic [N_SRC-1:0] pend_status
);
  localparam logic [CTL_W-1:0] KEEP = ctl_keep_mask();

  logic [CTL_W-1:0] ctl_r;
  logic [N_SRC-1:0] src_en;
  logic [N_SRC-1:0] src_set;
  logic [N_SRC-1:0] src_clr_any;
  logic [N_SRC-1:0] src_pend;
  logic [N_CH-1:0]  ch_en;
  logic [N_EV-1:0]  src_ev  [N_SRC];
  logic [N_CLR-1:0] src_clr [N_SRC];

  always_ff @(posedge clk) begin
    if (rst)         ctl_r <= '0;
    else if (ctl_we) ctl_r <= ctl_wdata & KEEP;
  end
  assign ctl_q = ctl_r;

  assign src_en = {ctl_r[BIT_DAQ], ctl_r[BIT_DAC], ctl_r[BIT_TC]};
  assign ch_en  = {ctl_r[BIT_DMA1], ctl_r[BIT_DMA0]};

  // Source routing: 0 terminal count, 1 output sequence, 2 acquisition.
  assign src_ev[0]  = {ev_tc_b, ev_tc_a};
  assign src_ev[1]  = {ev_dac_err, ev_dac_done};
  assign src_ev[2]  = {ev_daq_err, ev_daq_done};
  assign src_clr[0] = {1'b0, clr_tc};
  assign src_clr[1] = {clr_dac, clr_timer};
  assign src_clr[2] = {1'b0, clr_daq};

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    daq_src_latch #(.EV_W(N_EV), .CLR_W(N_CLR)) u_latch (
      .clk  (clk),
      .rst  (rst),
      .en   (src_en[s]),
      .ev   (src_ev[s]),
      .clr  (src_clr[s]),
      .set_o(src_set[s]),
      .clr_o(src_clr_any[s]),
      .pend (src_pend[s])
    );
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    daq_dma_chan u_chan (
      .clk    (clk),
      .rst    (rst),
      .en     (ch_en[c]),
      .ev_conv(ev_conv[c]),
      .ev_tmr (ev_tmr[c]),
      .ack    (dma_ack[c]),
      .req    (dma_req[c])
    );
  end

  assign irq         = |(src_pend & src_en);
  assign pend_status = src_pend;
endmodule

// File: rtl/daq_gate_chk.sv
module daq_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] src_en,
  input logic [2:0] src_set,
  input logic [2:0] src_clr,
  input logic [2:0] src_pend,
  input logic       irq,
  input logic [1:0] ch_en,
  input logic [1:0] dma_ack,
  input logic [1:0] dma_req
);
  // R2: a disabled, idle terminal-count latch cannot become pending
  a_r2_masked_no_set: assert property (@(posedge clk) disable iff (rst)
    (!src_en[0] && !src_pend[0]) |=> !src_pend[0]);

  // R4: a clear without a competing set empties the output-sequence latch
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (src_pend[1] && src_clr[1] && !src_set[1]) |=> !src_pend[1]);

  // R6: a set in the same cycle as a clear leaves the latch pending
  a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
    (src_set[1] && src_clr[1]) |=> src_pend[1]);

  // R7: no enabled pending source means no interrupt
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
    ((src_pend & src_en) == 3'b000) |-> !irq);

  // R8: a disabled channel never requests
  a_r8_ch1_off: assert property (@(posedge clk) disable iff (rst)
    !ch_en[1] |-> !dma_req[1]);

  // R9: an acknowledged request is low in the next cycle
  a_r9_ack_drop0: assert property (@(posedge clk) disable iff (rst)
    (dma_req[0] && dma_ack[0]) |=> !dma_req[0]);
  a_r9_ack_drop1: assert property (@(posedge clk) disable iff (rst)
    (dma_req[1] && dma_ack[1]) |=> !dma_req[1]);
endmodule

bind daq_irq_dma_gate daq_gate_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .src_en  (src_en),
  .src_set (src_set),
  .src_clr (src_clr_any),
  .src_pend(src_pend),
  .irq     (irq),
  .ch_en   (ch_en),
  .dma_ack (dma_ack),
  .dma_req (dma_req)
);

// File: tb/daq_irq_dma_gate_tb.sv
module daq_irq_dma_gate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_q;
  logic        ev_tc_a = 0, ev_tc_b = 0, ev_dac_done = 0, ev_dac_err = 0;
  logic        ev_daq_done = 0, ev_daq_err = 0;
  logic [1:0]  ev_conv = '0, ev_tmr = '0, dma_ack = '0, dma_req;
  logic        clr_tc = 0, clr_timer = 0, clr_dac = 0, clr_daq = 0;
  logic        irq;
  logic [2:0]  pend_status;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  daq_irq_dma_gate u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .ev_tc_a(ev_tc_a), .ev_tc_b(ev_tc_b), .ev_dac_done(ev_dac_done),
    .ev_dac_err(ev_dac_err), .ev_daq_done(ev_daq_done), .ev_daq_err(ev_daq_err),
    .ev_conv(ev_conv), .ev_tmr(ev_tmr), .clr_tc(clr_tc), .clr_timer(clr_timer),
    .clr_dac(clr_dac), .clr_daq(clr_daq), .dma_ack(dma_ack), .dma_req(dma_req),
    .irq(irq), .pend_status(pend_status)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: inputs settle after the edge, outputs are read after it.
  task automatic tick();
    @(posedge clk);
    #2;
    ctl_we = 0; ev_tc_a = 0; ev_tc_b = 0; ev_dac_done = 0; ev_dac_err = 0;
    ev_daq_done = 0; ev_daq_err = 0; ev_conv = '0; ev_tmr = '0; dma_ack = '0;
    clr_tc = 0; clr_timer = 0; clr_dac = 0; clr_daq = 0;
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    ctl_we = 1; ctl_wdata = v; tick();
  endtask

  // mask bit0 clr_tc, bit1 clr_timer, bit2 clr_dac, bit3 clr_daq
  task automatic set_clr(input logic [3:0] m);
    clr_tc = m[0]; clr_timer = m[1]; clr_dac = m[2]; clr_daq = m[3];
  endtask

  task automatic set_ev(input int src, input int kind);
    case (src)
      0: if (kind == 0) ev_tc_a = 1; else ev_tc_b = 1;
      1: if (kind == 0) ev_dac_done = 1; else ev_dac_err = 1;
      default: if (kind == 0) ev_daq_done = 1; else ev_daq_err = 1;
    endcase
  endtask

  function automatic logic [15:0] ctl_of(input logic [2:0] en, input logic [1:0] ch);
    return 16'(en[0]) << 12 | 16'(en[1]) << 11 | 16'(en[2]) << 10
         | 16'(ch[0]) << 8 | 16'(ch[1]) << 7;
  endfunction

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] own, foreign;
    logic [2:0] expd;
    repeat (3) tick();
    rst = 0;
    tick();
    chk("R10 ctl", ctl_q, 16'h0);
    chk("R10 pend", 16'(pend_status), 16'h0);
    chk("R10 irq", 16'(irq), 16'h0);
    chk("R10 dma", 16'(dma_req), 16'h0);

    wr_ctl(16'hFFFF); chk("R1 all", ctl_q, 16'h1F80);
    wr_ctl(16'h0A80); chk("R1 some", ctl_q, 16'h0A80);
    wr_ctl(16'h0000); chk("R1 zero", ctl_q, 16'h0000);

    // Interrupt sweep: R2 R3 R4 R5 R7
    for (int en = 0; en < 8; en++) begin
      for (int src = 0; src < 3; src++) begin
        for (int kind = 0; kind < 2; kind++) begin
          wr_ctl(ctl_of(3'(en), 2'b00));
          own     = (src == 0) ? 4'b0001 : (src == 1) ? ((kind == 0) ? 4'b0010 : 4'b0100) : 4'b1000;
          foreign = (src == 0) ? 4'b1110 : (src == 1) ? 4'b1001 : 4'b0111;
          set_ev(src, kind); tick();
          expd = ((en >> src) & 1) ? 3'(1 << src) : 3'b000;
          chk(src == 0 ? "R2 set" : src == 1 ? "R4 set" : "R5 set", 16'(pend_status), 16'(expd));
          chk("R7 irq", 16'(irq), 16'(expd != 0));
          set_clr(foreign); tick();
          chk(src == 0 ? "R3 foreign clr" : src == 1 ? "R4 foreign clr" : "R5 foreign clr",
              16'(pend_status), 16'(expd));
          set_clr(own); tick();
          chk(src == 0 ? "R3 own clr" : src == 1 ? "R4 own clr" : "R5 own clr",
              16'(pend_status), 16'h0);
        end
      end
    end

    // R6: event beats clear in the same cycle
    wr_ctl(ctl_of(3'b111, 2'b00));
    ev_tc_b = 1; clr_tc = 1; tick();
    chk("R6 tc", 16'(pend_status), 16'h1);
    ev_dac_err = 1; clr_timer = 1; clr_dac = 1; tick();
    chk("R6 dac", 16'(pend_status), 16'h3);
    set_clr(4'b1111); tick();
    chk("R6 cleared", 16'(pend_status), 16'h0);

    // R7: masking keeps the pending bit
    ev_daq_err = 1; tick();
    chk("R7 irq on", 16'(irq), 16'h1);
    wr_ctl(16'h0000);
    chk("R7 masked irq", 16'(irq), 16'h0);
    chk("R7 kept pend", 16'(pend_status), 16'h4);
    wr_ctl(ctl_of(3'b100, 2'b00));
    chk("R7 unmasked irq", 16'(irq), 16'h1);
    set_clr(4'b1000); tick();

    // DMA sweep: R8 R9
    for (int ch = 0; ch < 2; ch++) begin
      for (int en = 0; en < 2; en++) begin
        for (int src = 0; src < 2; src++) begin
          wr_ctl(ctl_of(3'b000, 2'(en << ch)));
          if (src == 0) ev_conv[ch] = 1; else ev_tmr[ch] = 1;
          tick();
          chk("R8 req", 16'(dma_req), 16'(en << ch));
          tick();
          chk("R9 hold", 16'(dma_req), 16'(en << ch));
          dma_ack[ch] = 1; tick();
          chk("R9 drop", 16'(dma_req), 16'h0);
          tick();
          chk("R9 stay low", 16'(dma_req), 16'h0);
        end
      end
      // event during the acknowledge cycle
      wr_ctl(ctl_of(3'b000, 2'(1 << ch)));
      ev_conv[ch] = 1; tick();
      dma_ack[ch] = 1; ev_tmr[ch] = 1; tick();
      chk("R9 gap", 16'(dma_req), 16'h0);
      tick();
      chk("R9 re-raise", 16'(dma_req), 16'(1 << ch));
      dma_ack[ch] = 1; tick();
      chk("R9 final drop", 16'(dma_req), 16'h0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule